// File: doc/BRIEF.md
# Bit-Field Insert and Mask Unit

This execution unit performs two related bit-field operations on 32-bit words. The insert operation overwrites a field of a base word with a small constant. The mask operation produces a word pair: the high word holds the field mask and the low word holds the constant shifted into the field's position. The field is described by a start position and a width. Both are 5-bit quantities.

A two-bit source select decides where position and width come from:
- both from immediate operands;
- position from the low 5 bits of a register word, with the width immediate;
- both from a register pair, with the width in the odd word and the position in the even word.

Only the all-immediate source has a legality limit. An operation that breaks it raises an undefined flag and returns zeros.

Each operation is presented with a one-cycle strobe. Its result appears, registered, on the following clock together with a valid flag. Instruction decode and the register file sit outside the block. The caller writes the high and low results to the odd and even registers of a destination pair.

Top module: `bfim_unit`

## Requirements
- R1: The field mask is (2^width - 1) shifted left by position, truncated to 32 bits. Bits carried above bit 31 are lost.
- R2: With in_op = 0 (insert), out_lo = (base AND NOT mask) OR ((value << position) AND mask), and out_hi = 0. The value is the 4-bit constant zero-extended.
- R3: With in_op = 1 (mask), out_hi = mask, and out_lo = the zero-extended value shifted left by position, truncated to 32 bits.
- R4: The source select in_mode chooses where position and width come from:
  - 0: position and width from in_pos_imm and in_wid_imm;
  - 1: position from in_reg_pos[4:0], width from in_wid_imm;
  - 2: position from in_reg_pos[4:0], width from in_reg_wid[4:0].
  Register bits 31:5 and unused immediates have no effect.
- R5: In mode 0, insert is undefined when position + width > 32, and mask is undefined when position + width > 31. Modes 1 and 2 are never undefined.
- R6: An undefined operation sets out_undef = 1 with out_lo = out_hi = 0. Mode 3 is reserved and is always undefined.
- R7: Width 0 yields a zero mask: insert returns the base unchanged, and mask returns out_hi = 0.
- R8: out_valid is high exactly one clock after a cycle with in_valid high. Results and out_undef change only on those clocks and hold otherwise.
- R9: A synchronous active-high rst clears out_valid, out_undef, out_lo and out_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 1 | 0 insert, 1 mask |
| in_mode | input | 2 | Position/width source select |
| in_base | input | 32 | Base word for insert |
| in_val | input | 4 | Constant to place in the field |
| in_pos_imm | input | 5 | Immediate position |
| in_wid_imm | input | 5 | Immediate width |
| in_reg_pos | input | 32 | Register word carrying the position |
| in_reg_wid | input | 32 | Register word carrying the width |
| out_valid | output | 1 | Result valid |
| out_undef | output | 1 | Result undefined |
| out_lo | output | 32 | Insert result, or shifted value for mask |
| out_hi | output | 32 | Field mask for mask, zero for insert |

## Verification
Every position and width pair from 0 to 31 is swept in all three sources, for both operations. Each operation uses a constant that varies with the pair and a base word with alternating bits, so wrong field edges, missing clears and wrong shifts all show up.

In the register sources, the upper register bits and the unused immediates carry random junk. Any dependence on them therefore changes a result. The immediate sweep crosses both legality limits, which separates the limit for insert from the limit for mask.

Separate cases cover:
- width 0;
- the reserved source;
- idle cycles, where the results must hold;
- reset.

// File: rtl/bfim_pkg.sv
package bfim_pkg;
   typedef enum logic {
      OP_INSERT = 1'b0,
      OP_IMASK  = 1'b1
   } bf_op_e;

   typedef enum logic [1:0] {
      SRC_IMM     = 2'd0,
      SRC_REGPOS  = 2'd1,
      SRC_REGPAIR = 2'd2,
      SRC_RSVD    = 2'd3
   } bf_src_e;
endpackage

// File: rtl/bfim_field_sel.sv
module bfim_field_sel
   import bfim_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int POS_W  = 5
) (
   input  bf_src_e           mode,
   input  bf_op_e            op,
   input  logic [POS_W-1:0]  pos_imm,
   input  logic [POS_W-1:0]  wid_imm,
   input  logic [DATA_W-1:0] reg_pos,
   input  logic [DATA_W-1:0] reg_wid,
   output logic [POS_W-1:0]  pos,
   output logic [POS_W-1:0]  wid,
   output logic              undef
);
   localparam int SUM_W = POS_W + 1;
   localparam logic [SUM_W-1:0] LIM_INSERT = SUM_W'(DATA_W);
   localparam logic [SUM_W-1:0] LIM_IMASK  = SUM_W'(DATA_W - 1);

   logic [SUM_W-1:0] imm_sum;
   logic             imm_bad;

   assign imm_sum = {1'b0, pos_imm} + {1'b0, wid_imm};

   always_comb begin
      if (op == OP_INSERT) imm_bad = (imm_sum > LIM_INSERT);
      else                 imm_bad = (imm_sum > LIM_IMASK);
   end

   always_comb begin
      pos   = '0;
      wid   = '0;
      undef = 1'b0;
      unique case (mode)
         SRC_IMM: begin
            pos   = pos_imm;
            wid   = wid_imm;
            undef = imm_bad;
         end
         SRC_REGPOS: begin
            pos = reg_pos[POS_W-1:0];
            wid = wid_imm;
         end
         SRC_REGPAIR: begin
            pos = reg_pos[POS_W-1:0];
            wid = reg_wid[POS_W-1:0];
         end
         default: undef = 1'b1;
      endcase
   end
endmodule

// File: rtl/bfim_mask_gen.sv
module bfim_mask_gen #(
   parameter int DATA_W     = 32,
   parameter int POS_W      = 5,
   parameter bit MASK_SHIFT = 1'b1
) (
   input  logic [POS_W-1:0]  pos,
   input  logic [POS_W-1:0]  wid,
   output logic [DATA_W-1:0] mask
);
   localparam int SUM_W = POS_W + 2;

   generate
      if (MASK_SHIFT) begin : g_shift
         logic [DATA_W-1:0] low_ones;
         assign low_ones = ~({DATA_W{1'b1}} << wid);
         assign mask     = low_ones << pos;
      end else begin : g_cmp
         logic [SUM_W-1:0] lo_edge;
         logic [SUM_W-1:0] hi_edge;
         assign lo_edge = SUM_W'(pos);
         assign hi_edge = SUM_W'(pos) + SUM_W'(wid);
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            localparam logic [SUM_W-1:0] IDX = SUM_W'(i);
            assign mask[i] = (IDX >= lo_edge) && (IDX < hi_edge);
         end
      end
   endgenerate
endmodule

// File: rtl/bfim_combine.sv
module bfim_combine
   import bfim_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int POS_W  = 5,
   parameter int VAL_W  = 4
) (
   input  bf_op_e            op,
   input  logic              undef,
   input  logic [DATA_W-1:0] base,
   input  logic [VAL_W-1:0]  val,
   input  logic [POS_W-1:0]  pos,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] res_lo,
   output logic [DATA_W-1:0] res_hi
);
   logic [DATA_W-1:0] val_ext;
   logic [DATA_W-1:0] val_sh;

   assign val_ext = DATA_W'(val);
   assign val_sh  = val_ext << pos;

   always_comb begin
      res_lo = '0;
      res_hi = '0;
      if (!undef) begin
         if (op == OP_INSERT) begin
            res_lo = (base & ~mask) | (val_sh & mask);
         end else begin
            res_lo = val_sh;
            res_hi = mask;
         end
      end
   end
endmodule

// File: rtl/bfim_unit.sv
module bfim_unit
   import bfim_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int VAL_W      = 4,
   parameter bit MASK_SHIFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_op,
   input  logic [1:0]        in_mode,
   input  logic [DATA_W-1:0] in_base,
   input  logic [VAL_W-1:0]  in_val,
   input  logic [$clog2(DATA_W)-1:0] in_pos_imm,
   input  logic [$clog2(DATA_W)-1:0] in_wid_imm,
   input  logic [DATA_W-1:0] in_reg_pos,
   input  logic [DATA_W-1:0] in_reg_wid,
   output logic              out_valid,
   output logic              out_undef,
   output logic [DATA_W-1:0] out_lo,
   output logic [DATA_W-1:0] out_hi
);
   localparam int POS_W = $clog2(DATA_W);

   generate
      if (DATA_W != (1 << POS_W)) begin : g_bad_width
         $error("bfim_unit: DATA_W must be a power of two");
      end
      if (VAL_W > DATA_W) begin : g_bad_val
         $error("bfim_unit: VAL_W must not exceed DATA_W");
      end
   endgenerate

   bf_op_e            op_c;
   bf_src_e           mode_c;
   logic [POS_W-1:0]  pos_c;
   logic [POS_W-1:0]  wid_c;
   logic              undef_c;
   logic [DATA_W-1:0] mask_c;
   logic [DATA_W-1:0] lo_c;
   logic [DATA_W-1:0] hi_c;

   assign op_c   = bf_op_e'(in_op);
   assign mode_c = bf_src_e'(in_mode);

   bfim_field_sel #(.DATA_W(DATA_W), .POS_W(POS_W)) u_sel (
      .mode    (mode_c),
      .op      (op_c),
      .pos_imm (in_pos_imm),
      .wid_imm (in_wid_imm),
      .reg_pos (in_reg_pos),
      .reg_wid (in_reg_wid),
      .pos     (pos_c),
      .wid     (wid_c),
      .undef   (undef_c)
   );

   bfim_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W), .MASK_SHIFT(MASK_SHIFT)) u_mask (
      .pos  (pos_c),
      .wid  (wid_c),
      .mask (mask_c)
   );

   bfim_combine #(.DATA_W(DATA_W), .POS_W(POS_W), .VAL_W(VAL_W)) u_comb (
      .op     (op_c),
      .undef  (undef_c),
      .base   (in_base),
      .val    (in_val),
      .pos    (pos_c),
      .mask   (mask_c),
      .res_lo (lo_c),
      .res_hi (hi_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_undef <= 1'b0;
         out_lo    <= '0;
         out_hi    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_undef <= undef_c;
            out_lo    <= lo_c;
            out_hi    <= hi_c;
         end
      end
   end

   AST_VALID_NEXT:    assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);  // R8
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R8
   AST_IDLE_HOLD:     assert property (@(posedge clk) disable iff (rst)
                         !in_valid |=> ($stable(out_lo) && $stable(out_hi) && $stable(out_undef))); // R8
   AST_UNDEF_ZERO:    assert property (@(posedge clk) disable iff (rst)
                         out_undef |-> (out_lo == '0 && out_hi == '0)); // R6
   AST_MASK_POP:      assert property (@(posedge clk) disable iff (rst)
                         in_valid |-> ($countones(mask_c) <= int'(wid_c))); // R1
   AST_REG_DEFINED:   assert property (@(posedge clk) disable iff (rst)
                         (in_valid && (in_mode == 2'd1 || in_mode == 2'd2)) |=> !out_undef); // R5
   AST_INSERT_HI:     assert property (@(posedge clk) disable iff (rst)
                         (in_valid && !in_op) |=> (out_hi == '0)); // R2
endmodule

// File: tb/bfim_unit_tb.sv
module bfim_unit_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_op = 1'b0;
   logic [1:0]  in_mode = 2'd0;
   logic [31:0] in_base = '0;
   logic [3:0]  in_val = '0;
   logic [4:0]  in_pos_imm = '0;
   logic [4:0]  in_wid_imm = '0;
   logic [31:0] in_reg_pos = '0;
   logic [31:0] in_reg_wid = '0;
   logic        out_valid;
   logic        out_undef;
   logic [31:0] out_lo;
   logic [31:0] out_hi;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bfim_unit u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_mode(in_mode),
      .in_base(in_base), .in_val(in_val), .in_pos_imm(in_pos_imm), .in_wid_imm(in_wid_imm),
      .in_reg_pos(in_reg_pos), .in_reg_wid(in_reg_wid),
      .out_valid(out_valid), .out_undef(out_undef), .out_lo(out_lo), .out_hi(out_hi)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_mask(input int p, input int w);
      logic [31:0] m = '0;
      for (int i = 0; i < 32; i++) if (i >= p && i < p + w) m[i] = 1'b1;
      return m;
   endfunction

   // drive at negedge, result registered at next posedge, checked at following negedge
   task automatic run_op(input bit op, input int mode, input int p, input int w,
                         input logic [31:0] base, input logic [3:0] v);
      logic [31:0] m, sh, exp_lo, exp_hi;
      bit und;
      string tg;
      in_valid = 1'b1;
      in_op    = op;
      in_mode  = 2'(mode);
      in_base  = base;
      in_val   = v;
      in_pos_imm = 5'($urandom);
      in_wid_imm = 5'($urandom);
      in_reg_pos = $urandom;
      in_reg_wid = $urandom;
      if (mode == 0) begin
         in_pos_imm = 5'(p);
         in_wid_imm = 5'(w);
      end else if (mode == 1) begin
         in_reg_pos[4:0] = 5'(p);
         in_wid_imm      = 5'(w);
      end else begin
         in_reg_pos[4:0] = 5'(p);
         in_reg_wid[4:0] = 5'(w);
      end
      @(negedge clk);
      m  = ref_mask(p, w);
      sh = {28'd0, v} << p;
      und = (mode == 3) || (mode == 0 && ((op == 1'b0 && p + w > 32) || (op == 1'b1 && p + w > 31)));
      if (und) begin
         exp_lo = '0;
         exp_hi = '0;
      end else if (!op) begin
         exp_lo = (base & ~m) | (sh & m);
         exp_hi = '0;
      end else begin
         exp_lo = sh;
         exp_hi = m;
      end
      if (mode == 3)      tg = "R6 reserved";
      else if (mode == 0) tg = op ? "R3/R5 imm" : "R2/R5 imm";
      else                tg = op ? "R3/R4 reg" : "R2/R4 reg";
      chk({tg, " undef"}, {31'd0, out_undef}, {31'd0, und});
      chk({tg, " lo"}, out_lo, exp_lo);
      chk(op ? "R1 mask hi" : {tg, " hi"}, out_hi, exp_hi);
      chk("R8 valid", {31'd0, out_valid}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset valid", {31'd0, out_valid}, 32'd0);
      chk("R9 reset undef", {31'd0, out_undef}, 32'd0);
      chk("R9 reset lo", out_lo, 32'd0);
      chk("R9 reset hi", out_hi, 32'd0);
      rst = 1'b0;

      for (int mode = 0; mode < 3; mode++)
         for (int p = 0; p < 32; p++)
            for (int w = 0; w < 32; w++)
               for (int op = 0; op < 2; op++)
                  run_op(op[0], mode, p, w, (p[0] ? 32'hA5A5_5A5A : 32'h5555_AAAA) ^ {27'd0, 5'(w)},
                         4'(p + w * 3 + 1));

      // R7: width zero
      run_op(1'b0, 0, 13, 0, 32'hDEAD_BEEF, 4'hF);
      chk("R7 insert w0 base kept", out_lo, 32'hDEAD_BEEF);
      run_op(1'b1, 2, 31, 0, 32'h0, 4'h9);
      chk("R7 imask w0 zero mask", out_hi, 32'h0);

      // R1: truncation above bit 31 in register mode
      run_op(1'b1, 1, 30, 31, 32'h0, 4'hF);
      chk("R1 truncated mask", out_hi, 32'hC000_0000);

      // R5: boundary of the two immediate limits
      run_op(1'b0, 0, 16, 16, 32'hFFFF_FFFF, 4'h0);
      chk("R5 insert at limit defined", {31'd0, out_undef}, 32'd0);
      run_op(1'b1, 0, 16, 16, 32'h0, 4'h1);
      chk("R5 imask over limit undef", {31'd0, out_undef}, 32'd1);

      // R6: reserved source
      run_op(1'b0, 3, 4, 4, 32'h1234_5678, 4'h7);
      run_op(1'b1, 3, 0, 1, 32'h0, 4'h1);

      // R8: idle cycles hold results
      run_op(1'b1, 0, 8, 4, 32'h0, 4'hC);
      in_valid = 1'b0;
      in_pos_imm = 5'd0;
      in_wid_imm = 5'd20;
      in_val = 4'h3;
      @(negedge clk);
      chk("R8 idle valid low", {31'd0, out_valid}, 32'd0);
      chk("R8 idle hi held", out_hi, 32'h0000_0F00);
      chk("R8 idle lo held", out_lo, 32'h0000_0C00);
      @(negedge clk);
      chk("R8 idle lo still held", out_lo, 32'h0000_0C00);

      // R9: reset mid-run
      run_op(1'b0, 0, 0, 8, 32'h0, 4'h5);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      chk("R9 reset lo", out_lo, 32'h0);
      chk("R9 reset valid", {31'd0, out_valid}, 32'd0);
      rst = 1'b0;

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule